// File: doc/BRIEF.md
# Boot Flash Write Protection Gate

This block decides, on every request to write the boot region of a serial flash, whether the write may go ahead. It sits between the host register interface and the flash write path. A control register holds three bits: a write enable, a lock, and a bit that restricts writes to system-management mode. A bank of protected address ranges, frozen by a lockdown bit, refuses writes to the pages it covers, whatever mode the CPU is in.

The lock makes write-enable changes visible to firmware. While the lock is set, any host write that sets the write enable raises a one-cycle management interrupt request. The management handler can then clear the enable again. The most restrictive setting is: lock set, management-mode-only set, write enable clear.

Top module: `flash_wp_gate`

## Requirements
- R1: After reset the write enable, lock, management-only bit, all range registers and the lockdown bit are 0. No request is granted and `smiReq` is low.
- R2: A request (`reqValid`=1) is granted in the same cycle when three conditions hold: the write enable is 1, no enabled protected range covers the address, and either the management-only bit is 0 or `inSmm` is 1.
- R3: In every cycle where `reqValid` is 1 and the request is not granted, `blockErr` is 1. `grant` and `blockErr` are never 1 together, and both are 0 while `reqValid` is 0.
- R4: The control register is at address 0, with bit0 the write enable, bit1 the lock and bit2 the management-only bit. If a control write with bit0=1 arrives while the lock was already 1 before that write, `smiReq` is 1 for exactly the one cycle after the write edge.
- R5: A control write with bit0=0, or any control write arriving while the lock was still 0 (including the write that sets the lock), leaves `smiReq` low.
- R6: The write enable takes the value of bit0 on every control write, whether or not the lock is set, so a handler can clear it.
- R7: The lock is set-once. Writing 0 to bit1 does not clear it; only reset does.
- R8: With the management-only bit set, a request with `inSmm`=0 is blocked even when the write enable is 1.
- R9: Range i (0..3) is at address 1+i. Bits [11:0] hold the base page, bits [23:12] the limit page, and bit24 the enable; a page is 4 KiB. An address is blocked when `reqAddr[23:12]` lies between base and limit, both ends included, in any enabled range. This holds even with `inSmm`=1.
- R10: The lockdown bit is bit0 at address 5 and is set-once. Once it is 1, writes to the range registers have no effect.
- R11: With lock=1, management-only=1 and write enable=0, every request is blocked, whether or not the CPU is in management mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 3 | Host register address |
| regWrData | input | 25 | Host register write data |
| inSmm | input | 1 | CPU is in system-management mode |
| reqValid | input | 1 | Flash write request present |
| reqAddr | input | 24 | Flash byte address of the request |
| grant | output | 1 | Request honoured this cycle |
| blockErr | output | 1 | Request refused this cycle |
| smiReq | output | 1 | One-cycle management interrupt request |

## Verification
Two things can fall in the same cycle: a host write that changes the control bits, and a flash request judged against those bits. The request must be judged on the value the register held before the edge. The bench presents a request in the same cycle as a write that sets or clears the write enable, and compares `grant` against the old value. It then presents the request again after the edge and compares against the new value. The same pairing covers the write that sets the lock and the enable together, which must raise no interrupt request.

// File: rtl/fwpg_pkg.sv
package fwpg_pkg;
  localparam int NUM_RANGES = 4;
  localparam int ADDR_W     = 24;
  localparam int PAGE_SHIFT = 12;
  localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;
  localparam int DATA_W     = 2 * PAGE_W + 1;
  localparam int REG_AW     = $clog2(NUM_RANGES + 2);
  localparam logic [REG_AW-1:0] CTRL_ADDR = '0;
  localparam logic [REG_AW-1:0] LOCK_ADDR = REG_AW'(NUM_RANGES + 1);
  localparam int WE_BIT   = 0;
  localparam int LOCK_BIT = 1;
  localparam int SMMO_BIT = 2;

  typedef struct packed {
    logic                  ctrlWr;
    logic [NUM_RANGES-1:0] rangeWr;
    logic                  lockdownWr;
    logic [DATA_W-1:0]     data;
  } wrStrobe_t;
endpackage

// File: rtl/fwpg_ctrl.sv
module fwpg_ctrl
  import fwpg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              lockEnQ,
  output wrStrobe_t         stb,
  output logic              smiReq
);
  always_comb begin
    stb = '0;
    stb.data = regWrData;
    stb.ctrlWr = regWrEn && (regAddr == CTRL_ADDR);
    stb.lockdownWr = regWrEn && (regAddr == LOCK_ADDR);
    for (int i = 0; i < NUM_RANGES; i++)
      stb.rangeWr[i] = regWrEn && (regAddr == REG_AW'(i + 1));
  end

  // lock value sampled before the write edge decides the interrupt
  always_ff @(posedge clk) begin
    if (!rstN) smiReq <= 1'b0;
    else       smiReq <= stb.ctrlWr && regWrData[WE_BIT] && lockEnQ;
  end

  // R5
  no_smi_unlocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockEnQ |=> !smiReq);
endmodule

// File: rtl/fwpg_datapath.sv
module fwpg_datapath
  import fwpg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  logic              inSmm,
  input  logic              reqValid,
  input  logic [PAGE_W-1:0] reqPage,
  output logic              grant,
  output logic              blockErr,
  output logic              lockEnQ,
  output logic              wrEnQ
);
  logic smmOnlyQ, lockdownQ;
  logic [NUM_RANGES-1:0][PAGE_W-1:0] baseQ, limitQ;
  logic [NUM_RANGES-1:0] rangeOnQ, rangeHit;
  logic pass;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEnQ <= 1'b0; lockEnQ <= 1'b0; smmOnlyQ <= 1'b0; lockdownQ <= 1'b0;
    end else begin
      if (stb.ctrlWr) begin
        wrEnQ    <= stb.data[WE_BIT];
        lockEnQ  <= lockEnQ | stb.data[LOCK_BIT];
        smmOnlyQ <= stb.data[SMMO_BIT];
      end
      if (stb.lockdownWr) lockdownQ <= lockdownQ | stb.data[0];
    end
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[g] <= '0; limitQ[g] <= '0; rangeOnQ[g] <= 1'b0;
      end else if (stb.rangeWr[g] && !lockdownQ) begin
        baseQ[g]    <= stb.data[PAGE_W-1:0];
        limitQ[g]   <= stb.data[2*PAGE_W-1:PAGE_W];
        rangeOnQ[g] <= stb.data[2*PAGE_W];
      end
    end
    assign rangeHit[g] = rangeOnQ[g] && (reqPage >= baseQ[g]) && (reqPage <= limitQ[g]);
  end

  assign pass     = wrEnQ && (!smmOnlyQ || inSmm) && (rangeHit == '0);
  assign grant    = reqValid && pass;
  assign blockErr = reqValid && !pass;

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockEnQ |=> lockEnQ);
  // R10
  lockdown_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockdownQ |=> lockdownQ);
  // R10
  ranges_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockdownQ |=> ($stable(baseQ) && $stable(limitQ) && $stable(rangeOnQ)));
  // R11
  secure_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockEnQ && smmOnlyQ && !wrEnQ && reqValid) |-> blockErr);
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import fwpg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              inSmm,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              grant,
  output logic              blockErr,
  output logic              smiReq
);
  wrStrobe_t stb;
  logic lockEnQ, wrEnQ;
  logic unusedPageOffset;
  assign unusedPageOffset = ^reqAddr[PAGE_SHIFT-1:0];

  fwpg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .lockEnQ(lockEnQ), .stb(stb), .smiReq(smiReq));

  fwpg_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inSmm(inSmm), .reqValid(reqValid),
    .reqPage(reqAddr[ADDR_W-1:PAGE_SHIFT]), .grant(grant), .blockErr(blockErr),
    .lockEnQ(lockEnQ), .wrEnQ(wrEnQ));

  // R4
  smi_implies_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> (wrEnQ && lockEnQ));
  // R3
  decision_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && blockErr) && ((grant || blockErr) == reqValid));
endmodule

// File: tb/flash_wp_gate_tb.sv
module flash_wp_gate_tb;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rstN = 0;
  logic regWrEn = 0; logic [2:0] regAddr = 0; logic [24:0] regWrData = 0;
  logic inSmm = 0, reqValid = 0; logic [23:0] reqAddr = 0;
  logic grant, blockErr, smiReq;
  int checks = 0, errors = 0;

  logic mWe, mLock, mSmmo, mLd;
  logic [11:0] mBase [4]; logic [11:0] mLim [4]; logic mOn [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wp_gate u_dut (.clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .inSmm(inSmm), .reqValid(reqValid), .reqAddr(reqAddr),
    .grant(grant), .blockErr(blockErr), .smiReq(smiReq));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic expGrant(input logic [23:0] a, input logic smm);
    logic hit = 0;
    for (int i = 0; i < 4; i++)
      if (mOn[i] && a[23:12] >= mBase[i] && a[23:12] <= mLim[i]) hit = 1;
    return mWe && (!mSmmo || smm) && !hit;
  endfunction

  task automatic modelReset();
    mWe = 0; mLock = 0; mSmmo = 0; mLd = 0;
    for (int i = 0; i < 4; i++) begin mBase[i] = 0; mLim[i] = 0; mOn[i] = 0; end
  endtask

  // host write; optional concurrent request judged on pre-write state
  task automatic hostWrite(input logic [2:0] a, input logic [24:0] d,
                           input logic doReq, input logic [23:0] ra, input logic smm);
    logic expSmi, g;
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    reqValid = doReq; reqAddr = ra; inSmm = smm;
    #1;
    if (doReq) begin
      g = expGrant(ra, smm);
      chk("R2 same-cycle grant", grant, g);
      chk("R3 same-cycle block", blockErr, !g);
    end
    expSmi = (a == 0) && d[0] && mLock;
    @(posedge clk);
    if (a == 0) begin mWe = d[0]; mLock = mLock | d[1]; mSmmo = d[2]; end
    else if (a == 5) mLd = mLd | d[0];
    else if (a >= 1 && a <= 4 && !mLd) begin
      mBase[a-1] = d[11:0]; mLim[a-1] = d[23:12]; mOn[a-1] = d[24];
    end
    #1;
    chk(expSmi ? "R4 smi pulse" : "R5 no smi", smiReq, expSmi);
    regWrEn = 0; reqValid = 0;
    @(posedge clk); #1;
    chk("R4 smi one cycle", smiReq, 1'b0);
  endtask

  task automatic request(input logic [23:0] ra, input logic smm, input string req);
    logic g;
    @(negedge clk);
    reqValid = 1; reqAddr = ra; inSmm = smm;
    #1;
    g = expGrant(ra, smm);
    chk(req, grant, g);
    chk("R3 block flag", blockErr, !g);
    @(negedge clk);
    reqValid = 0;
    #1;
    chk("R3 idle", grant | blockErr, 1'b0);
  endtask

  function automatic logic [24:0] rng(input logic [11:0] b, input logic [11:0] l, input logic on);
    return {on, l, b};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    chk("R1 smi reset", smiReq, 1'b0);
    request(24'h123456, 1'b1, "R1 no grant after reset");

    // R6 enable then grant; same-cycle clear judged on old value
    hostWrite(3'd0, 25'h1, 0, 0, 0);
    request(24'h000100, 1'b0, "R2 granted");
    hostWrite(3'd0, 25'h0, 1, 24'h000100, 0);
    request(24'h000100, 1'b0, "R6 cleared blocks");
    // R5 lock and enable in the same write: no smi
    hostWrite(3'd0, 25'h3, 0, 0, 0);
    request(24'h000100, 1'b0, "R2 granted locked");
    // R7 writing lock=0 keeps lock: next enable still raises smi
    hostWrite(3'd0, 25'h0, 0, 0, 0);
    hostWrite(3'd0, 25'h1, 0, 0, 0);
    // R6 handler clears
    hostWrite(3'd0, 25'h0, 0, 0, 0);
    request(24'h000100, 1'b1, "R6 handler cleared");
    // R8 smm-only
    hostWrite(3'd0, 25'h5, 0, 0, 0);
    request(24'h000100, 1'b0, "R8 outside smm blocked");
    request(24'h000100, 1'b1, "R8 inside smm granted");
    // R9 range in smm with boundaries
    hostWrite(3'd1, rng(12'h010, 12'h01F, 1), 0, 0, 0);
    request(24'h010000, 1'b1, "R9 base page blocked");
    request(24'h01FFFF, 1'b1, "R9 limit page blocked");
    request(24'h020000, 1'b1, "R9 above limit granted");
    request(24'h00FFFF, 1'b1, "R9 below base granted");
    hostWrite(3'd2, rng(12'h100, 12'h100, 0), 0, 0, 0);
    request(24'h100800, 1'b1, "R9 disabled range granted");
    // R10 lockdown freezes ranges
    hostWrite(3'd5, 25'h1, 0, 0, 0);
    hostWrite(3'd1, rng(12'h000, 12'h000, 0), 0, 0, 0);
    request(24'h015000, 1'b1, "R10 frozen range still blocks");
    hostWrite(3'd5, 25'h0, 0, 0, 0);
    hostWrite(3'd2, rng(12'h100, 12'h100, 1), 0, 0, 0);
    request(24'h100800, 1'b1, "R10 lockdown kept");
    // R11 secure setting
    hostWrite(3'd0, 25'h6, 0, 0, 0);
    request(24'h300000, 1'b1, "R11 secure blocks in smm");
    request(24'h300000, 1'b0, "R11 secure blocks");

    // random phase after reset
    @(negedge clk); rstN = 0; @(negedge clk); rstN = 1; modelReset();
    for (int it = 0; it < 400; it++) begin
      int k = $urandom_range(0, 9);
      logic [11:0] b = 12'($urandom_range(0, 4095));
      if (k < 2) hostWrite(3'd0, 25'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                           24'($urandom), 1'($urandom_range(0, 1)));
      else if (k < 4) hostWrite(3'($urandom_range(1, 4)),
                           rng(b, b + 12'($urandom_range(0, 300)), 1'($urandom_range(0, 1))), 0, 0, 0);
      else if (k == 4 && $urandom_range(0, 20) == 0) hostWrite(3'd5, 25'h1, 0, 0, 0);
      else request(24'($urandom), 1'($urandom_range(0, 1)), "R2 random request");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule